// File: doc/BRIEF.md
# Predicated Interleaved Vector Store Sequencer

The sequencer turns one store command into a stream of single-item memory writes. It takes data from a group of one to four vector registers held in its own register-file model. For each element index it checks a governing predicate. When the element is active it writes that element from every register of the group to consecutive memory slots. When the element is inactive it writes nothing but still advances the address. Each element can be narrowed to a smaller memory item, in which case only its low bytes are written.

A command gives the first register, the predicate (one bit per vector byte), a byte base address, the vector length in bytes, the element size, the memory item size and the register count. Element and item sizes are encoded as log2 of the byte count (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). The register count is encoded as count minus one. Writes leave on a valid/ready port. A one-cycle done pulse marks the end of the command.

Top module: `vst_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_valid_o` and `done_o` are 0.
- R2: For an active element index e, the block writes N items in order, where N = `nreg_i`+1. Item k comes from register (`first_reg_i`+k) and goes to address base + (e·N + k)·msize.
- R3: Element indices are visited in ascending order. The address steps by N·msize per element index whether the element is active or not, and an inactive element produces no write.
- R4: Element e is active exactly when predicate bit e·esize (its lowest byte) is 1. The other predicate bits of the element have no effect.
- R5: Register k of the group is (`first_reg_i` + k) modulo 32, so a group that starts at register 30 continues with registers 31, 0 and 1.
- R6: `wr_size_o` equals the item size code. `wr_data_o` carries the low msize bytes of the element in little-endian order, and all higher data bits are 0.
- R7: While `wr_valid_o` is 1 and `wr_ready_i` is 0, the valid signal, address, data and size hold unchanged into the next cycle.
- R8: `done_o` pulses for exactly one cycle after the last element index has been handled, also when no element is active. In that cycle the block is idle and accepts a new `start_i`.
- R9: A `start_i` that arrives while a command is running is ignored and does not alter the running command's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rf_we_i | input | 1 | Register-file write enable |
| rf_idx_i | input | 5 | Register-file write index |
| rf_data_i | input | VLEN_MAX·8 | Register-file write data, byte 0 in bits 7:0 |
| start_i | input | 1 | Start a command (taken only when idle) |
| first_reg_i | input | 5 | First register of the group |
| pred_i | input | VLEN_MAX | Governing predicate, one bit per vector byte |
| base_addr_i | input | ADDR_W | Byte base address |
| vl_bytes_i | input | clog2(VLEN_MAX)+1 | Vector length in bytes, multiple of 16 |
| esz_i | input | 2 | Element size code (log2 bytes) |
| msz_i | input | 2 | Memory item size code, not above esz_i; must equal esz_i when nreg_i > 0 |
| nreg_i | input | 2 | Register count minus one |
| wr_valid_o | output | 1 | Write item valid |
| wr_ready_i | input | 1 | Memory accepts the item |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 64 | Write data, zero above the item size |
| wr_size_o | output | 2 | Write size code (log2 bytes) |
| done_o | output | 1 | One-cycle command completion pulse |

## Verification
The completion pulse and the acceptance of the next command can fall in the same cycle, because the done cycle is already idle. The bench provokes this by raising `start_i` for a second command in exactly the cycle where `done_o` is seen for the first. It then judges that the first command's item list is complete with one done pulse, and that the second command's items all follow in full. It also raises `start_i` in the middle of a stalled run and checks that the write stream still matches the first command alone.

// File: rtl/vst_pkg.sv
package vst_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} vst_state_e;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned ITEM_W    = 64;
endpackage

// File: rtl/vst_regfile.sv
module vst_regfile #(
  parameter int unsigned VBITS = 512,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [VBITS-1:0] wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [VBITS-1:0] rdata_o
);
  localparam int unsigned NUM = 1 << IDX_W;

  logic [VBITS-1:0] mem_q [NUM];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/vst_lane_pick.sv
module vst_lane_pick #(
  parameter int unsigned VLEN_MAX = 64
) (
  input  logic [VLEN_MAX*8-1:0]       vec_i,
  input  logic [$clog2(VLEN_MAX)-1:0] off_i,
  input  logic [1:0]                  msz_i,
  output logic [63:0]                 item_o
);
  localparam int unsigned VBITS = VLEN_MAX * 8;

  logic [VBITS-1:0] shifted;
  logic [63:0]      raw;

  assign shifted = vec_i >> {off_i, 3'b000};
  assign raw     = shifted[63:0];

  // Narrowing: keep low bytes only
  always_comb begin
    unique case (msz_i)
      2'd0:    item_o = {56'd0, raw[7:0]};
      2'd1:    item_o = {48'd0, raw[15:0]};
      2'd2:    item_o = {32'd0, raw[31:0]};
      default: item_o = raw;
    endcase
  end
endmodule

// File: rtl/vst_seq_ctrl.sv
module vst_seq_ctrl
  import vst_pkg::*;
#(
  parameter int unsigned VLEN_MAX = 64,
  parameter int unsigned ADDR_W   = 32,
  localparam int unsigned VL_W    = $clog2(VLEN_MAX) + 1,
  localparam int unsigned OFF_W   = $clog2(VLEN_MAX)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [REG_IDX_W-1:0] first_reg_i,
  input  logic [VLEN_MAX-1:0]  pred_i,
  input  logic [ADDR_W-1:0]    base_addr_i,
  input  logic [VL_W-1:0]      vl_bytes_i,
  input  logic [1:0]           esz_i,
  input  logic [1:0]           msz_i,
  input  logic [1:0]           nreg_i,
  input  logic                 wr_ready_i,
  output logic                 wr_valid_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [1:0]           msz_o,
  output logic [REG_IDX_W-1:0] rd_idx_o,
  output logic [OFF_W-1:0]     byte_off_o,
  output logic                 busy_o,
  output logic                 done_o
);
  vst_state_e           state_q;
  logic [REG_IDX_W-1:0] first_q;
  logic [VLEN_MAX-1:0]  pred_q;
  logic [1:0]           esz_q, msz_q, nreg_q, k_q;
  logic [VL_W-1:0]      elem_q, last_q, off_full;
  logic [ADDR_W-1:0]    addr_q, step_item, step_skip;
  logic                 done_q, running, active, accept, last_item, elem_end;

  assign running    = (state_q == ST_RUN);
  assign off_full   = elem_q << esz_q;
  assign byte_off_o = off_full[OFF_W-1:0];
  assign active     = pred_q[byte_off_o];
  assign wr_valid_o = running && active;
  assign accept     = wr_valid_o && wr_ready_i;
  assign last_item  = (k_q == nreg_q);
  assign elem_end   = running && (!active || (accept && last_item));
  assign step_item  = ADDR_W'(1) << msz_q;
  assign step_skip  = ADDR_W'({1'b0, nreg_q} + 3'd1) << msz_q;

  assign wr_addr_o  = addr_q;
  assign msz_o      = msz_q;
  assign rd_idx_o   = first_q + REG_IDX_W'(k_q);
  assign busy_o     = running;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      first_q <= '0;
      pred_q  <= '0;
      esz_q   <= '0;
      msz_q   <= '0;
      nreg_q  <= '0;
      k_q     <= '0;
      elem_q  <= '0;
      last_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!running) begin
        if (start_i) begin
          state_q <= ST_RUN;
          first_q <= first_reg_i;
          pred_q  <= pred_i;
          esz_q   <= esz_i;
          msz_q   <= msz_i;
          nreg_q  <= nreg_i;
          k_q     <= '0;
          elem_q  <= '0;
          last_q  <= (vl_bytes_i >> esz_i) - VL_W'(1);
          addr_q  <= base_addr_i;
        end
      end else begin
        if (!active) addr_q <= addr_q + step_skip;
        else if (accept) begin
          addr_q <= addr_q + step_item;
          k_q    <= last_item ? 2'd0 : k_q + 2'd1;
        end
        if (elem_end) begin
          if (elem_q == last_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            elem_q <= elem_q + VL_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/vst_seq.sv
module vst_seq
  import vst_pkg::*;
#(
  parameter int unsigned VLEN_MAX = 64,
  parameter int unsigned ADDR_W   = 32,
  localparam int unsigned VBITS   = VLEN_MAX * 8,
  localparam int unsigned VL_W    = $clog2(VLEN_MAX) + 1,
  localparam int unsigned OFF_W   = $clog2(VLEN_MAX)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rf_we_i,
  input  logic [REG_IDX_W-1:0] rf_idx_i,
  input  logic [VBITS-1:0]     rf_data_i,
  input  logic                 start_i,
  input  logic [REG_IDX_W-1:0] first_reg_i,
  input  logic [VLEN_MAX-1:0]  pred_i,
  input  logic [ADDR_W-1:0]    base_addr_i,
  input  logic [VL_W-1:0]      vl_bytes_i,
  input  logic [1:0]           esz_i,
  input  logic [1:0]           msz_i,
  input  logic [1:0]           nreg_i,
  output logic                 wr_valid_o,
  input  logic                 wr_ready_i,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [ITEM_W-1:0]    wr_data_o,
  output logic [1:0]           wr_size_o,
  output logic                 done_o
);
  logic [REG_IDX_W-1:0] rd_idx;
  logic [OFF_W-1:0]     byte_off;
  logic [VBITS-1:0]     rd_vec;
  logic [1:0]           msz;
  logic                 busy;

  vst_seq_ctrl #(.VLEN_MAX(VLEN_MAX), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .first_reg_i (first_reg_i),
    .pred_i      (pred_i),
    .base_addr_i (base_addr_i),
    .vl_bytes_i  (vl_bytes_i),
    .esz_i       (esz_i),
    .msz_i       (msz_i),
    .nreg_i      (nreg_i),
    .wr_ready_i  (wr_ready_i),
    .wr_valid_o  (wr_valid_o),
    .wr_addr_o   (wr_addr_o),
    .msz_o       (msz),
    .rd_idx_o    (rd_idx),
    .byte_off_o  (byte_off),
    .busy_o      (busy),
    .done_o      (done_o)
  );

  vst_regfile #(.VBITS(VBITS), .IDX_W(REG_IDX_W)) u_rf (
    .clk_i   (clk_i),
    .we_i    (rf_we_i),
    .widx_i  (rf_idx_i),
    .wdata_i (rf_data_i),
    .ridx_i  (rd_idx),
    .rdata_o (rd_vec)
  );

  vst_lane_pick #(.VLEN_MAX(VLEN_MAX)) u_pick (
    .vec_i  (rd_vec),
    .off_i  (byte_off),
    .msz_i  (msz),
    .item_o (wr_data_o)
  );

  assign wr_size_o = msz;
endmodule

// File: rtl/vst_seq_chk.sv
module vst_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_i,
  input logic              wr_valid_i,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [63:0]       wr_data_i,
  input logic [1:0]        wr_size_i,
  input logic              done_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!wr_valid_i && !done_i);
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !wr_ready_i |=> wr_valid_i && $stable(wr_addr_i)
      && $stable(wr_data_i) && $stable(wr_size_i));

  p_narrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> (wr_data_i >> (8 << wr_size_i)) == 64'd0);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !wr_valid_i && !busy_i);

  p_start_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && start_i |=> $stable(wr_size_i));
endmodule

bind vst_seq vst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_i     (busy),
  .wr_valid_i (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_i  (wr_addr_o),
  .wr_data_i  (wr_data_o),
  .wr_size_i  (wr_size_o),
  .done_i     (done_o)
);

// File: tb/vst_seq_bench.sv
`timescale 1ns/1ps
module vst_seq_bench;
  localparam int VL    = 64;
  localparam int VBITS = VL * 8;
  localparam int AW    = 32;
  localparam int VLW   = $clog2(VL) + 1;

  logic             clk_i = 1'b0;
  logic             rst_n;
  logic             rf_we;
  logic [4:0]       rf_idx;
  logic [VBITS-1:0] rf_data;
  logic             start;
  logic [4:0]       first;
  logic [VL-1:0]    pred;
  logic [AW-1:0]    base;
  logic [VLW-1:0]   vlb;
  logic [1:0]       esz, msz, nreg;
  logic             wr_valid, wr_ready;
  logic [AW-1:0]    wr_addr;
  logic [63:0]      wr_data;
  logic [1:0]       wr_size;
  logic             done;

  vst_seq #(.VLEN_MAX(VL), .ADDR_W(AW)) u_vst_seq (
    .clk_i(clk_i), .rst_ni(rst_n), .rf_we_i(rf_we), .rf_idx_i(rf_idx),
    .rf_data_i(rf_data), .start_i(start), .first_reg_i(first), .pred_i(pred),
    .base_addr_i(base), .vl_bytes_i(vlb), .esz_i(esz), .msz_i(msz),
    .nreg_i(nreg), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_size_o(wr_size),
    .done_o(done)
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit [VBITS-1:0] breg [32];
  logic [AW-1:0]  exp_addr [512];
  logic [63:0]    exp_data [512];
  logic [1:0]     exp_size [512];
  int exp_n;
  logic [AW-1:0]  cap_addr [512];
  logic [63:0]    cap_data [512];
  logic [1:0]     cap_size [512];
  int cap_n = 0, done_cnt = 0;
  bit stall_mode = 1'b0;
  int cyc = 0;
  bit prev_hold = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [63:0]   prev_data;
  logic [1:0]    prev_size;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    wr_ready = stall_mode ? (cyc % 3 != 1) : 1'b1;
  end

  // Monitor at negedge+1
  always @(negedge clk_i) begin
    #1;
    if (rst_n === 1'b1) begin
      if (prev_hold) begin
        chk(wr_valid === 1'b1 && wr_addr == prev_addr && wr_data == prev_data
            && wr_size == prev_size, "R7", "stalled item held",
            longint'(wr_addr), longint'(prev_addr));
      end
      prev_hold = wr_valid && !wr_ready;
      prev_addr = wr_addr;
      prev_data = wr_data;
      prev_size = wr_size;
      if (wr_valid && wr_ready && cap_n < 512) begin
        cap_addr[cap_n] = wr_addr;
        cap_data[cap_n] = wr_data;
        cap_size[cap_n] = wr_size;
        cap_n++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic build_exp(input int f, input logic [VL-1:0] p, input int b,
                           input int v, input int ez, input int mz, input int nr);
    int es = 1 << ez, ms = 1 << mz, nn = nr + 1;
    exp_n = 0;
    for (int e = 0; e < v / es; e++) begin
      if (p[e * es]) begin
        for (int k = 0; k < nn; k++) begin
          bit [VBITS-1:0] sh = breg[(f + k) % 32] >> (e * es * 8);
          logic [63:0] d = sh[63:0];
          if (ms < 8) d = d & ((64'd1 << (ms * 8)) - 64'd1);
          exp_addr[exp_n] = AW'(b + (e * nn + k) * ms);
          exp_data[exp_n] = d;
          exp_size[exp_n] = 2'(mz);
          exp_n++;
        end
      end
    end
  endtask

  task automatic compare(input string req);
    chk(cap_n == exp_n, req, "item count", cap_n, exp_n);
    for (int i = 0; i < cap_n && i < exp_n; i++) begin
      chk(cap_addr[i] == exp_addr[i], req, $sformatf("addr item %0d", i),
          longint'(cap_addr[i]), longint'(exp_addr[i]));
      chk(cap_data[i] == exp_data[i], req, $sformatf("data item %0d", i),
          longint'(cap_data[i]), longint'(exp_data[i]));
      chk(cap_size[i] == exp_size[i], "R6", $sformatf("size item %0d", i),
          longint'(cap_size[i]), longint'(exp_size[i]));
    end
  endtask

  task automatic set_cmd(input int f, input logic [VL-1:0] p, input int b,
                         input int v, input int ez, input int mz, input int nr);
    first = 5'(f); pred = p; base = AW'(b); vlb = VLW'(v);
    esz = 2'(ez); msz = 2'(mz); nreg = 2'(nr);
  endtask

  // Called at negedge+2: start seen at next posedge
  task automatic launch_now();
    cap_n = 0; done_cnt = 0; prev_hold = 1'b0;
    start = 1'b1;
    @(negedge clk_i); #2;
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (done !== 1'b1 && t < 4000) begin
      @(negedge clk_i); #2;
      t++;
    end
    if (done !== 1'b1) chk(1'b0, req, "watchdog, no done", 0, 1);
  endtask

  task automatic settle_and_check(input string req);
    int n_at_done = cap_n;
    repeat (3) begin @(negedge clk_i); #2; end
    chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    chk(cap_n == n_at_done, "R8", "no writes after done", cap_n, n_at_done);
    compare(req);
  endtask

  task automatic run_cmd(input string req, input int f, input logic [VL-1:0] p,
                         input int b, input int v, input int ez, input int mz,
                         input int nr);
    build_exp(f, p, b, v, ez, mz, nr);
    @(negedge clk_i); #2;
    set_cmd(f, p, b, v, ez, mz, nr);
    launch_now();
    wait_done(req);
    settle_and_check(req);
  endtask

  task automatic test_reset();
    #1;
    chk(wr_valid === 1'b0, "R1", "valid in reset", longint'(wr_valid), 0);
    chk(done === 1'b0, "R1", "done in reset", longint'(done), 0);
  endtask

  task automatic test_reset_exit();
    @(negedge clk_i); #2;
    chk(wr_valid === 1'b0 && done === 1'b0, "R1", "idle after reset",
        longint'({wr_valid, done}), 0);
  endtask

  task automatic load_regs();
    for (int r = 0; r < 32; r++) begin
      bit [VBITS-1:0] v;
      for (int bb = 0; bb < VL; bb++) v[bb*8 +: 8] = 8'((r * 37 + bb * 11 + 5) ^ (bb >> 2));
      breg[r] = v;
      @(negedge clk_i);
      rf_we = 1'b1; rf_idx = 5'(r); rf_data = v;
    end
    @(negedge clk_i);
    rf_we = 1'b0;
  endtask

  task automatic test_st1_bytes();        // R2 R3 single register, full
    stall_mode = 1'b0;
    run_cmd("R2", 3, 64'hFFFF, 32'h1000, 16, 0, 0, 0);
  endtask

  task automatic test_narrow();           // R6 narrowing 8-byte to 2-byte
    stall_mode = 1'b1;
    run_cmd("R6", 7, 64'h0101_0000_0001_0101, 32'h2002, 64, 3, 1, 0);
  endtask

  task automatic test_wrap_four();        // R5 R4 group 30,31,0,1
    stall_mode = 1'b1;
    run_cmd("R5", 30, 64'h0000_0000_E0F1_0E01, 32'h3000, 32, 2, 2, 3);
  endtask

  task automatic test_none_active();      // R4 R8 only non-lowest bits set
    stall_mode = 1'b0;
    run_cmd("R4", 5, 64'hFEFE_FEFE_FEFE_FEFE, 32'h4000, 64, 3, 0, 0);
  endtask

  task automatic test_three_mixed();      // R3 address skips inactive elements
    stall_mode = 1'b0;
    run_cmd("R3", 12, 64'h0000_0F00_00FF_0001, 32'h5008, 48, 3, 3, 2);
  endtask

  task automatic test_busy_start();       // R9
    stall_mode = 1'b1;
    build_exp(10, 64'h5555_5555, 32'h6000, 32, 1, 1, 1);
    @(negedge clk_i); #2;
    set_cmd(10, 64'h5555_5555, 32'h6000, 32, 1, 1, 1);
    launch_now();
    repeat (3) begin @(negedge clk_i); #2; end
    set_cmd(0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h9999, 64, 0, 0, 0);
    start = 1'b1;
    @(negedge clk_i); #2;
    start = 1'b0;
    wait_done("R9");
    settle_and_check("R9");
  endtask

  task automatic test_back_to_back();     // R8 start in done cycle
    stall_mode = 1'b0;
    build_exp(0, 64'h0000_0000_00FF_0101, 32'h7000, 32, 3, 3, 1);
    @(negedge clk_i); #2;
    set_cmd(0, 64'h0000_0000_00FF_0101, 32'h7000, 32, 3, 3, 1);
    launch_now();
    wait_done("R8");
    chk(done_cnt == 1, "R8", "first done pulse", done_cnt, 1);
    compare("R8");
    build_exp(31, 64'hA5C3, 32'h7100, 16, 0, 0, 1);
    set_cmd(31, 64'hA5C3, 32'h7100, 16, 0, 0, 1);
    launch_now();
    wait_done("R8");
    settle_and_check("R8");
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b1; rf_we = 1'b0; rf_idx = '0; rf_data = '0; start = 1'b0;
    set_cmd(0, '0, 0, 16, 0, 0, 0);
    #1 rst_n = 1'b0;
    test_reset();
    repeat (3) @(negedge clk_i);
    rst_n = 1'b1;
    test_reset_exit();
    load_regs();
    test_st1_bytes();
    test_narrow();
    test_wrap_four();
    test_none_active();
    test_three_mixed();
    test_busy_start();
    test_back_to_back();
    finish_up();
  end
endmodule